// File: doc/BRIEF.md
# Conversion Result Hardware Averager

This block sits between a successive-approximation converter core and the result register that software reads. Each raw conversion result arrives with a one-cycle valid strobe. With averaging turned off, every result goes straight to the result register and raises the completion flag. With averaging turned on, results are summed over a group of 4, 8, 16 or 32 conversions. Only the final member of the group writes the truncated mean to the result register and raises the flag.

While a group is still filling, the block pulses a request output after each result. This tells the converter to start the next conversion without outside help. The largest group size is the one used for calibration runs. The completion flag stays set until a read acknowledge or a new start request clears it. A start request, or any change to the averaging controls, throws away a partially filled group.

Top module: `conv_mean_unit`

## Requirements
- R1: While reset is active and in the first cycle after it, `doneFlag` is 0, `convMore` is 0 and `resultData` is 0.
- R2: With `avgEn` = 0 (averaging off), a valid sample is copied to `resultData` on the next clock edge and `doneFlag` is set in the same cycle.
- R3: With `avgEn` = 1, `sizeSel` picks the group size: code 0 gives 4, code 1 gives 8, code 2 gives 16 and code 3 gives 32. The final sample of a group writes floor(sum / size) to `resultData`.
- R4: In averaging mode, a sample that does not complete its group leaves `doneFlag` clear after a start request, and it does not change `resultData`.
- R5: `convMore` is a one-cycle pulse in the cycle after each non-final sample of a group. It stays 0 after the final sample and in bypass mode.
- R6: `doneFlag` holds until `readAck` or `startReq` clears it. If a completion and `readAck` fall in the same cycle, the flag ends up set.
- R7: `startReq` clears `doneFlag` and discards any partial group. A sample presented in the same cycle as `startReq` is ignored.
- R8: A change of `avgEn` or `sizeSel` discards the partial sum and count. A sample presented in the cycle of the change is ignored.
- R9: The accumulator has room for 32 full-scale samples, so 32 samples of 0xFFFF average to exactly 0xFFFF.
- R10: Groups can follow one another with only a start request in between. Each mean depends only on its own group's samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| avgEn | input | 1 | 1 = average groups, 0 = bypass |
| sizeSel | input | 2 | Group size code (4, 8, 16, 32) |
| startReq | input | 1 | New start request; clears flag and partial group |
| sampleValid | input | 1 | Raw result strobe |
| sampleData | input | SAMPLE_W | Raw conversion result |
| readAck | input | 1 | Clears the completion flag |
| resultData | output | SAMPLE_W | Result register |
| doneFlag | output | 1 | Completion flag |
| convMore | output | 1 | Request for the next conversion of the group |

## Verification
The checker applies several rules on every cycle:
- the flag rises only after a sample;
- the flag holds unless it is acknowledged or restarted;
- a start request leaves both the flag and the request output low;
- the request pulse always follows an averaging sample;
- a bypass sample lands unchanged in the result register.

The values of the group means can only be shown by the bench's scenarios. The same holds for the full-scale overflow case, for discarding a group on restart or on a change of controls, and for back-to-back groups. The bench computes each expected mean from its own sample sequence.

// File: rtl/conv_mean_pkg.sv
package conv_mean_pkg;
  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic clrAcc;   // zero accumulator
    logic addAcc;   // add sample, group not full
    logic commit;   // final sample: write mean
    logic passThru; // bypass: copy sample
  } avgStrobes_t;
endpackage

// File: rtl/conv_mean_ctrl.sv
module conv_mean_ctrl
  import conv_mean_pkg::*;
#(
  parameter int SEL_W    = 2,
  parameter int MIN_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             avgEn,
  input  logic [SEL_W-1:0] sizeSel,
  input  logic             startReq,
  input  logic             sampleValid,
  input  logic             readAck,
  output avgStrobes_t      strb,
  output logic             doneFlag,
  output logic             convMore
);
  localparam int MAX_LOG2 = MIN_LOG2 + (2 ** SEL_W) - 1;
  localparam int CNT_W    = MAX_LOG2;

  logic             avgEnQ;
  logic [SEL_W-1:0] sizeQ;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   groupN;
  logic             cfgChg, accept, isLast;

  always_comb begin
    groupN = (CNT_W+1)'(1) << (CNT_W'(sizeSel) + CNT_W'(MIN_LOG2));
    cfgChg = (avgEn != avgEnQ) || (sizeSel != sizeQ);
    accept = sampleValid && !startReq && !cfgChg;
    isLast = ({1'b0, cnt} == groupN - (CNT_W+1)'(1));
    strb.passThru = accept && !avgEn;
    strb.commit   = accept && avgEn && isLast;
    strb.addAcc   = accept && avgEn && !isLast;
    strb.clrAcc   = startReq || cfgChg || strb.commit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      avgEnQ   <= 1'b0;
      sizeQ    <= '0;
      cnt      <= '0;
      doneFlag <= 1'b0;
      convMore <= 1'b0;
    end else begin
      avgEnQ   <= avgEn;
      sizeQ    <= sizeSel;
      convMore <= strb.addAcc;
      if (strb.clrAcc)      cnt <= '0;
      else if (strb.addAcc) cnt <= cnt + CNT_W'(1);
      if (strb.commit || strb.passThru) doneFlag <= 1'b1;
      else if (readAck || startReq)     doneFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/conv_mean_dp.sv
module conv_mean_dp
  import conv_mean_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int SEL_W    = 2,
  parameter int MIN_LOG2 = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  avgStrobes_t         strb,
  input  logic [SEL_W-1:0]    sizeSel,
  input  logic [SAMPLE_W-1:0] sampleData,
  output logic [SAMPLE_W-1:0] resultData
);
  localparam int MAX_LOG2 = MIN_LOG2 + (2 ** SEL_W) - 1;
  localparam int ACC_W    = SAMPLE_W + MAX_LOG2;
  localparam int SH_W     = $clog2(MAX_LOG2 + 1);

  logic [ACC_W-1:0] acc, sumNext, meanFull;
  logic [SH_W-1:0]  shAmt;

  always_comb begin
    sumNext  = acc + ACC_W'(sampleData);
    shAmt    = SH_W'(sizeSel) + SH_W'(MIN_LOG2);
    meanFull = sumNext >> shAmt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc        <= '0;
      resultData <= '0;
    end else begin
      if (strb.clrAcc)      acc <= '0;
      else if (strb.addAcc) acc <= sumNext;
      if (strb.commit)        resultData <= meanFull[SAMPLE_W-1:0];
      else if (strb.passThru) resultData <= sampleData;
    end
  end
endmodule

// File: rtl/conv_mean_unit.sv
module conv_mean_unit
  import conv_mean_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int SEL_W    = 2,
  parameter int MIN_LOG2 = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                avgEn,
  input  logic [SEL_W-1:0]    sizeSel,
  input  logic                startReq,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                readAck,
  output logic [SAMPLE_W-1:0] resultData,
  output logic                doneFlag,
  output logic                convMore
);
  avgStrobes_t strb;

  conv_mean_ctrl #(.SEL_W(SEL_W), .MIN_LOG2(MIN_LOG2)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .avgEn(avgEn), .sizeSel(sizeSel),
    .startReq(startReq), .sampleValid(sampleValid), .readAck(readAck),
    .strb(strb), .doneFlag(doneFlag), .convMore(convMore)
  );

  conv_mean_dp #(.SAMPLE_W(SAMPLE_W), .SEL_W(SEL_W), .MIN_LOG2(MIN_LOG2)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .sizeSel(sizeSel),
    .sampleData(sampleData), .resultData(resultData)
  );
endmodule

// File: rtl/conv_mean_unit_chk.sv
module conv_mean_unit_chk #(
  parameter int SAMPLE_W = 16,
  parameter int SEL_W    = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                avgEn,
  input logic [SEL_W-1:0]    sizeSel,
  input logic                startReq,
  input logic                sampleValid,
  input logic [SAMPLE_W-1:0] sampleData,
  input logic                readAck,
  input logic [SAMPLE_W-1:0] resultData,
  input logic                doneFlag,
  input logic                convMore
);
  // R4
  flag_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(doneFlag) |-> $past(sampleValid));

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doneFlag && !readAck && !startReq |=> doneFlag);

  // R7
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    startReq |=> !doneFlag && !convMore);

  // R5
  more_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    convMore |-> $past(sampleValid && avgEn && !startReq));

  // R2
  bypass_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sampleValid && !avgEn && !startReq && $stable(avgEn) && $stable(sizeSel)
    |=> doneFlag && (resultData == $past(sampleData)));
endmodule

bind conv_mean_unit conv_mean_unit_chk #(.SAMPLE_W(SAMPLE_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .avgEn(avgEn), .sizeSel(sizeSel),
  .startReq(startReq), .sampleValid(sampleValid), .sampleData(sampleData),
  .readAck(readAck), .resultData(resultData), .doneFlag(doneFlag),
  .convMore(convMore)
);

// File: tb/tb_conv_mean_unit.sv
module tb_conv_mean_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        avgEn = 1'b0;
  logic [1:0]  sizeSel = 2'd0;
  logic        startReq = 1'b0;
  logic        sampleValid = 1'b0;
  logic [15:0] sampleData = '0;
  logic        readAck = 1'b0;
  logic [15:0] resultData;
  logic        doneFlag, convMore;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  conv_mean_unit dut (
    .clk(clk), .rst_n(rst_n), .avgEn(avgEn), .sizeSel(sizeSel),
    .startReq(startReq), .sampleValid(sampleValid), .sampleData(sampleData),
    .readAck(readAck), .resultData(resultData), .doneFlag(doneFlag),
    .convMore(convMore)
  );

  // {size code, first sample, step}
  localparam logic [33:0] VEC [0:5] = '{
    {2'd0, 16'd100,   16'd4},
    {2'd1, 16'd1000,  16'd3},
    {2'd2, 16'h8000,  16'h0101},
    {2'd3, 16'hFFFF,  16'd0},
    {2'd3, 16'd7,     16'd13},
    {2'd0, 16'd1,     16'd1}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulseSample(input logic [15:0] d, input logic ack);
    sampleValid = 1'b1; sampleData = d; readAck = ack;
    tick();
    sampleValid = 1'b0; readAck = 1'b0;
  endtask

  task automatic doStart();
    startReq = 1'b1; tick(); startReq = 1'b0;
  endtask

  task automatic setMode(input logic en, input logic [1:0] sz);
    avgEn = en; sizeSel = sz; tick();
  endtask

  // Runs a full group; checks R3/R4/R5/R9/R10
  task automatic runGroup(input logic [1:0] sz, input logic [15:0] base,
                          input logic [15:0] step, input string tag);
    int n = 4 << sz;
    longint sum = 0;
    logic [15:0] prev;
    setMode(1'b1, sz);
    doStart();
    prev = resultData;
    for (int i = 0; i < n; i++) begin
      logic [15:0] s = base + 16'(i) * step;
      sum += s;
      pulseSample(s, 1'b0);
      if (i < n - 1) begin
        check({"R5 more ", tag}, convMore, 1);
        check({"R4 flag ", tag}, doneFlag, 0);
        check({"R4 hold ", tag}, resultData, prev);
      end else begin
        check({"R5 last ", tag}, convMore, 0);
        check({"R3 flag ", tag}, doneFlag, 1);
        check({"R3 mean ", tag}, resultData, int'(sum / n));
      end
    end
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    check("R1 flag", doneFlag, 0);
    check("R1 more", convMore, 0);
    check("R1 result", resultData, 0);
    rst_n = 1'b1; tick();
    check("R1 after flag", doneFlag, 0);
    check("R1 after result", resultData, 0);

    // Table walk (R3, R9 in entry 3, R10 back to back)
    for (int v = 0; v < 6; v++)
      runGroup(VEC[v][33:32], VEC[v][31:16], VEC[v][15:0], $sformatf("R10 vec%0d", v));

    // R2 bypass
    setMode(1'b0, 2'd0);
    pulseSample(16'h1234, 1'b0);
    check("R2 result", resultData, 16'h1234);
    check("R2 flag", doneFlag, 1);
    check("R5 bypass more", convMore, 0);
    pulseSample(16'hBEEF, 1'b0);
    check("R2 second", resultData, 16'hBEEF);

    // R6 sticky, ack, set wins over ack
    tick(); tick();
    check("R6 sticky", doneFlag, 1);
    readAck = 1'b1; tick(); readAck = 1'b0;
    check("R6 ack clears", doneFlag, 0);
    pulseSample(16'h0042, 1'b1);
    check("R6 set wins", doneFlag, 1);

    // R7 start clears flag; sample with start ignored; partial discarded
    setMode(1'b1, 2'd0);
    pulseSample(16'd1000, 1'b0);
    pulseSample(16'd1000, 1'b0);
    startReq = 1'b1; sampleValid = 1'b1; sampleData = 16'd5000; tick();
    startReq = 1'b0; sampleValid = 1'b0;
    check("R7 flag cleared", doneFlag, 0);
    check("R7 no more", convMore, 0);
    for (int i = 0; i < 4; i++) pulseSample(16'd8, 1'b0);
    check("R7 mean fresh", resultData, 8);
    check("R7 flag set", doneFlag, 1);

    // R8 size change discards partial; sample in change cycle ignored
    doStart();
    pulseSample(16'd4000, 1'b0);
    pulseSample(16'd4000, 1'b0);
    sizeSel = 2'd1; sampleValid = 1'b1; sampleData = 16'd9999; tick();
    sampleValid = 1'b0;
    check("R8 change no more", convMore, 0);
    for (int i = 0; i < 8; i++) pulseSample(16'(i * 2), 1'b0);
    check("R8 size mean", resultData, 7);
    // R8 avgEn toggle discards partial
    doStart();
    pulseSample(16'd60000, 1'b0);
    avgEn = 1'b0; tick();
    avgEn = 1'b1; tick();
    for (int i = 0; i < 8; i++) pulseSample(16'd20, 1'b0);
    check("R8 toggle mean", resultData, 20);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule